// File: doc/BRIEF.md
# Block-Tagged Test Pattern Generator and Checker

This block feeds a 32-bit test stream into a write FIFO and checks a 32-bit stream that comes back out of a read FIFO. The stream is cut into 512-byte blocks of 128 dwords. The first two dwords of every block carry a 64-bit tag equal to the block's address in 512-byte units. The remaining 126 dwords carry a pattern that restarts from that address, so no two blocks in a run look alike.

A one-cycle start pulse latches the run settings: the pattern code, the first file index, the file count and the file size in blocks. The pulse then opens a write run whose length is the file count times the file size. The write side moves only while the FIFO is not almost full. The read side pops the FIFO whenever it holds data and compares each dword with a locally regenerated copy. A sticky flag records a mismatch, and capture registers hold the details of the first one. A byte counter reports the traffic of the current run.

Top module: `tpg_block_tagger`

## Requirements
- R1: While reset is held, `wr_en` and `fail` are 0, `byte_count` is 0, and `rd_en` is 0 when `rd_empty` is 1.
- R2: The start pulse captures `pat_sel`, `start_file`, `file_count` and `file_blocks`. Changing these inputs afterwards has no effect on the run in progress. The run becomes active on the clock edge that samples the start pulse. While the run is active, `wr_en` is 1 exactly when `wr_afull` is 0, and it is 0 in every cycle in which `wr_afull` is 1.
- R3: The first block address is `start_file * file_blocks`, and each block after it adds 1. Dword 0 of a block is address bits [31:0] and dword 1 is address bits [63:32]. This holds for both the written stream and the expected read stream.
- R4: With code 000, dword k of a block (k = 2..127) is address[31:0] + (k - 2), modulo 2^32. With code 001, it is the bitwise inverse of that value.
- R5: Code 010 gives 0x00000000 and code 011 gives 0xFFFFFFFF in dwords 2..127. Codes 101, 110 and 111 also give 0x00000000.
- R6: With code 100, dword 2 is {address[30:0], 1}. Each following dword is the previous value s stepped as {s[30:0], s[31]^s[21]^s[1]^s[0]}.
- R7: A run writes exactly `file_count * file_blocks * 128` dwords, after which `wr_en` stays 0. A count of zero writes nothing.
- R8: `rd_en` equals NOT `rd_empty` at all times, with or without a start pulse. The FIFO returns the dword one cycle after `rd_en`, and the block compares that dword against the expected stream.
- R9: A mismatch sets `fail`, which stays at 1. The first mismatch alone loads `fail_exp` (expected dword), `fail_rd` (read dword), `fail_byte` (byte offset within its file) and `fail_file` (file index = `start_file` + files completed so far).
- R10: A start pulse clears `fail`, the four capture outputs and `byte_count` to 0, and restarts both streams from the new first address.
- R11: `byte_count` adds 4 for each written dword and 4 for each compared read dword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle run start |
| pat_sel | input | 3 | Pattern code |
| start_file | input | 27 | First file index |
| file_count | input | 27 | Number of files in the run |
| file_blocks | input | 30 | File size in 512-byte blocks |
| wr_afull | input | 1 | Write FIFO almost full |
| wr_en | output | 1 | Write FIFO push |
| wr_data | output | 32 | Write FIFO data |
| rd_empty | input | 1 | Read FIFO empty |
| rd_en | output | 1 | Read FIFO pop |
| rd_data | input | 32 | Read FIFO data, valid one cycle after the pop |
| fail | output | 1 | Sticky mismatch flag |
| fail_exp | output | 32 | Expected dword at first mismatch |
| fail_rd | output | 32 | Read dword at first mismatch |
| fail_byte | output | 39 | Byte offset in file at first mismatch |
| fail_file | output | 27 | File index at first mismatch |
| byte_count | output | 56 | Running byte count |

## Verification
`wr_en` and `rd_en` are combinational and must follow `wr_afull` and `rd_empty` within the same cycle. The bench changes those inputs just after a rising edge and reads the enables at the next falling edge. The run becomes active, the byte count grows and the fail flag and captures load on the edge that samples their cause, so each is read half a cycle after that edge. The bench's FIFO model puts a popped dword on `rd_data` at the falling edge that follows the pop, which makes the comparison happen at the second edge after `rd_empty` falls. Written data goes through a scoreboard queue: expected dwords are pushed before the start pulse, and one is popped at every falling edge on which `wr_en` is high.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [2:0] {
        PAT_INC  = 3'b000,
        PAT_DEC  = 3'b001,
        PAT_ZERO = 3'b010,
        PAT_ONE  = 3'b011,
        PAT_LFSR = 3'b100
    } pat_sel_e;

    // Shift left; feedback from bits 31, 21, 1 and 0 of the current state.
    // Bit 31 is in the feedback, so a nonzero state never becomes zero.
    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Bit 0 is forced to 1, so the seed is never zero.
    function automatic logic [31:0] lfsr_seed(input logic [30:0] a);
        return {a, 1'b1};
    endfunction

endpackage

// File: rtl/tpg_pattern_gen.sv
module tpg_pattern_gen
    import tpg_pkg::*;
#(
    parameter int BLK_W      = 57,
    parameter int DW_PER_BLK = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BLK_W-1:0] base_blk,
    input  logic [2:0]       sel,
    input  logic             advance,
    output logic [31:0]      data
);
    localparam int IDX_W  = $clog2(DW_PER_BLK);
    localparam int HDR_DW = 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DW_PER_BLK - 1);
    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_DW - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [BLK_W-1:0] blk;
        logic [31:0]      inc;
        logic [31:0]      lfsr;
    } gen_st_t;

    gen_st_t st_q, st_d;
    logic [63:0] tag64;

    assign tag64 = 64'(st_q.blk);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.idx  = '0;
            st_d.blk  = base_blk;
            st_d.inc  = '0;
            st_d.lfsr = '0;
        end else if (advance) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.idx = '0;
                st_d.blk = st_q.blk + BLK_W'(1);
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
                if (st_q.idx == HDR_LAST) begin
                    st_d.inc  = st_q.blk[31:0];
                    st_d.lfsr = lfsr_seed(st_q.blk[30:0]);
                end else begin
                    st_d.inc  = st_q.inc + 32'd1;
                    st_d.lfsr = lfsr_step(st_q.lfsr);
                end
            end
        end
    end

    always_comb begin
        if (st_q.idx == '0) begin
            data = tag64[31:0];
        end else if (st_q.idx == HDR_LAST) begin
            data = tag64[63:32];
        end else begin
            case (pat_sel_e'(sel))
                PAT_INC:  data = st_q.inc;
                PAT_DEC:  data = ~st_q.inc;
                PAT_ONE:  data = 32'hFFFF_FFFF;
                PAT_LFSR: data = st_q.lfsr;
                default:  data = 32'h0000_0000;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    blk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && st_q.idx == LAST_IDX) |=>
            (st_q.blk == $past(st_q.blk) + BLK_W'(1)) && (st_q.idx == '0));

    // R4
    seed_from_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && st_q.idx == HDR_LAST) |=>
            (st_q.inc == $past(st_q.blk[31:0])));

endmodule

// File: rtl/tpg_write_ctrl.sv
module tpg_write_ctrl #(
    parameter int TOT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TOT_W-1:0] total_in,
    input  logic             afull,
    output logic             wr_en
);
    typedef struct packed {
        logic             active;
        logic [TOT_W-1:0] total;
        logic [TOT_W-1:0] cnt;
    } wr_st_t;

    wr_st_t st_q, st_d;

    assign wr_en = st_q.active & ~afull;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = (total_in != '0);
            st_d.total  = total_in;
            st_d.cnt    = '0;
        end else if (wr_en) begin
            st_d.cnt = st_q.cnt + TOT_W'(1);
            if (st_q.cnt + TOT_W'(1) == st_q.total) st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    cnt_within_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.total);

    // R7
    active_below_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.cnt < st_q.total));

    // R2
    rise_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> $past(start));

endmodule

// File: rtl/tpg_read_check.sv
module tpg_read_check #(
    parameter int IDX_W   = 27,
    parameter int FADDR_W = 39
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [IDX_W-1:0]   start_file,
    input  logic [FADDR_W-1:0] file_bytes,
    input  logic               rd_empty,
    input  logic [31:0]        rd_data,
    input  logic [31:0]        exp_data,
    output logic               rd_en,
    output logic               rd_vld,
    output logic               fail,
    output logic [31:0]        cap_exp,
    output logic [31:0]        cap_rd,
    output logic [FADDR_W-1:0] cap_byte,
    output logic [IDX_W-1:0]   cap_file
);
    typedef struct packed {
        logic               vld;
        logic [FADDR_W-1:0] pos;
        logic [IDX_W-1:0]   file;
        logic               fail;
        logic [31:0]        c_exp;
        logic [31:0]        c_rd;
        logic [FADDR_W-1:0] c_byte;
        logic [IDX_W-1:0]   c_file;
    } rd_st_t;

    rd_st_t st_q, st_d;
    logic   mismatch;

    assign rd_en    = ~rd_empty;
    assign rd_vld   = st_q.vld;
    assign mismatch = st_q.vld && (rd_data != exp_data);

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_en;
        if (start) begin
            st_d.pos    = '0;
            st_d.file   = start_file;
            st_d.fail   = 1'b0;
            st_d.c_exp  = '0;
            st_d.c_rd   = '0;
            st_d.c_byte = '0;
            st_d.c_file = '0;
        end else if (st_q.vld) begin
            if (mismatch && !st_q.fail) begin
                st_d.fail   = 1'b1;
                st_d.c_exp  = exp_data;
                st_d.c_rd   = rd_data;
                st_d.c_byte = st_q.pos;
                st_d.c_file = st_q.file;
            end
            if (st_q.pos + FADDR_W'(4) == file_bytes) begin
                st_d.pos  = '0;
                st_d.file = st_q.file + IDX_W'(1);
            end else begin
                st_d.pos = st_q.pos + FADDR_W'(4);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fail     = st_q.fail;
    assign cap_exp  = st_q.c_exp;
    assign cap_rd   = st_q.c_rd;
    assign cap_byte = st_q.c_byte;
    assign cap_file = st_q.c_file;

    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fail && !start) |=> st_q.fail);

    // R9
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fail && !start) |=> ($stable(st_q.c_exp) && $stable(st_q.c_rd) &&
                                   $stable(st_q.c_byte) && $stable(st_q.c_file)));

    // R9
    fail_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fail) |-> $past(mismatch));

endmodule

// File: rtl/tpg_block_tagger.sv
module tpg_block_tagger
    import tpg_pkg::*;
#(
    parameter int IDX_W      = 27,
    parameter int FSZ_W      = 30,
    parameter int DW_PER_BLK = 128,
    parameter int BCNT_W     = 56
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [2:0]                   pat_sel,
    input  logic [IDX_W-1:0]             start_file,
    input  logic [IDX_W-1:0]             file_count,
    input  logic [FSZ_W-1:0]             file_blocks,
    input  logic                         wr_afull,
    output logic                         wr_en,
    output logic [31:0]                  wr_data,
    input  logic                         rd_empty,
    output logic                         rd_en,
    input  logic [31:0]                  rd_data,
    output logic                         fail,
    output logic [31:0]                  fail_exp,
    output logic [31:0]                  fail_rd,
    output logic [FSZ_W+$clog2(DW_PER_BLK*4)-1:0] fail_byte,
    output logic [IDX_W-1:0]             fail_file,
    output logic [BCNT_W-1:0]            byte_count
);
    localparam int DW_SH   = $clog2(DW_PER_BLK);
    localparam int BYTE_SH = $clog2(DW_PER_BLK * 4);
    localparam int BLK_W   = IDX_W + FSZ_W;
    localparam int TOT_W   = IDX_W + FSZ_W + DW_SH;
    localparam int FADDR_W = FSZ_W + BYTE_SH;
    localparam int N_SIDE  = 2;

    typedef struct packed {
        logic [2:0]         sel;
        logic [FADDR_W-1:0] fbytes;
        logic [BCNT_W-1:0]  bcnt;
    } top_st_t;

    top_st_t st_q, st_d;

    logic [BLK_W-1:0]         base_blk;
    logic [TOT_W-1:0]         total_dw;
    logic                     rd_vld;
    logic [N_SIDE-1:0]        side_adv;
    logic [N_SIDE-1:0][31:0]  side_dat;

    assign base_blk = BLK_W'(start_file) * BLK_W'(file_blocks);
    assign total_dw = (TOT_W'(file_count) * TOT_W'(file_blocks)) << DW_SH;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.sel    = pat_sel;
            st_d.fbytes = FADDR_W'(file_blocks) << BYTE_SH;
            st_d.bcnt   = '0;
        end else begin
            st_d.bcnt = st_q.bcnt +
                        BCNT_W'({wr_en & rd_vld, wr_en ^ rd_vld, 2'b00});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign side_adv[0] = wr_en;
    assign side_adv[1] = rd_vld;

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        tpg_pattern_gen #(
            .BLK_W      (BLK_W),
            .DW_PER_BLK (DW_PER_BLK)
        ) u_gen (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (start),
            .base_blk (base_blk),
            .sel      (st_q.sel),
            .advance  (side_adv[s]),
            .data     (side_dat[s])
        );
    end

    assign wr_data = side_dat[0];

    tpg_write_ctrl #(
        .TOT_W (TOT_W)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .total_in (total_dw),
        .afull    (wr_afull),
        .wr_en    (wr_en)
    );

    tpg_read_check #(
        .IDX_W   (IDX_W),
        .FADDR_W (FADDR_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_file (start_file),
        .file_bytes (st_q.fbytes),
        .rd_empty   (rd_empty),
        .rd_data    (rd_data),
        .exp_data   (side_dat[1]),
        .rd_en      (rd_en),
        .rd_vld     (rd_vld),
        .fail       (fail),
        .cap_exp    (fail_exp),
        .cap_rd     (fail_rd),
        .cap_byte   (fail_byte),
        .cap_file   (fail_file)
    );

    assign byte_count = st_q.bcnt;

    // R11
    bytecnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (st_q.bcnt >= $past(st_q.bcnt)));

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (byte_count == '0) && !fail);

    // R2
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_afull |-> !wr_en);

endmodule

// File: tb/tpg_block_tagger_tb_top.sv
module tpg_block_tagger_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  pat_sel = 3'b000;
    logic [26:0] start_file = '0;
    logic [26:0] file_count = '0;
    logic [29:0] file_blocks = '0;
    logic        wr_afull = 1'b0;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        rd_empty = 1'b1;
    logic        rd_en;
    logic [31:0] rd_data = '0;
    logic        fail;
    logic [31:0] fail_exp, fail_rd;
    logic [38:0] fail_byte;
    logic [26:0] fail_file;
    logic [55:0] byte_count;

    tpg_block_tagger dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_sel(pat_sel),
        .start_file(start_file), .file_count(file_count), .file_blocks(file_blocks),
        .wr_afull(wr_afull), .wr_en(wr_en), .wr_data(wr_data),
        .rd_empty(rd_empty), .rd_en(rd_en), .rd_data(rd_data),
        .fail(fail), .fail_exp(fail_exp), .fail_rd(fail_rd),
        .fail_byte(fail_byte), .fail_file(fail_file), .byte_count(byte_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int cyc = 0;
    bit afull_on = 1'b0;
    bit stall_on = 1'b0;
    bit mon_on = 1'b0;
    int wr_seen = 0;
    int afull_viol = 0;
    string cur_req = "R4";

    logic [31:0] gm[$];
    logic [31:0] exp_q[$];
    logic [31:0] feed_q[$];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lfsr_nx(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Reference stream built from the requirements
    task automatic build(input logic [63:0] blk0, input int nblk, input logic [2:0] sel);
        gm.delete();
        for (int b = 0; b < nblk; b++) begin
            logic [63:0] blk;
            logic [31:0] inc, lf, v;
            blk = blk0 + 64'(b);
            gm.push_back(blk[31:0]);
            gm.push_back(blk[63:32]);
            inc = blk[31:0];
            lf  = {blk[30:0], 1'b1};
            for (int k = 2; k < 128; k++) begin
                case (sel)
                    3'b000:  v = inc;
                    3'b001:  v = ~inc;
                    3'b011:  v = 32'hFFFF_FFFF;
                    3'b100:  v = lf;
                    default: v = 32'h0;
                endcase
                gm.push_back(v);
                inc = inc + 32'd1;
                lf  = lfsr_nx(lf);
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        #1 wr_afull = afull_on && ((cyc % 7) < 2);
    end

    // Write monitor: scoreboard pop
    always @(negedge clk) begin
        if (wr_en) begin
            wr_seen++;
            if (wr_afull) afull_viol++;
            if (mon_on && exp_q.size() > 0) begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(cur_req, 64'(wr_data), 64'(e));
            end
        end
    end

    // Read FIFO model: data appears one cycle after pop
    always @(negedge clk) begin
        if (rst_n) chk("R8", 64'(rd_en), 64'(!rd_empty));
        if (rd_en) rd_data = (feed_q.size() > 0) ? feed_q.pop_front() : 32'h0;
        rd_empty = (feed_q.size() == 0) || (stall_on && ((cyc % 4) == 1));
    end

    task automatic do_start(input logic [2:0] sel, input logic [26:0] sf,
                            input logic [26:0] fc, input logic [29:0] fb);
        @(posedge clk); #2;
        pat_sel = sel; start_file = sf; file_count = fc; file_blocks = fb;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic run_write(input logic [2:0] sel, input logic [26:0] sf,
                             input logic [26:0] fc, input logic [29:0] fb,
                             input string req, input bit af, input bit chg);
        int n;
        build(64'(sf) * 64'(fb), int'(fc) * int'(fb), sel);
        exp_q = gm;
        n = exp_q.size();
        cur_req = req;
        afull_on = af;
        mon_on = 1'b1;
        wr_seen = 0;
        afull_viol = 0;
        do_start(sel, sf, fc, fb);
        if (!af) chk("R2", 64'(wr_en), 64'(1));
        if (chg) begin
            repeat (40) @(posedge clk);
            #2 pat_sel = 3'b011;
        end
        wait (exp_q.size() == 0);
        repeat (20) @(posedge clk);
        #2;
        chk("R7", 64'(wr_seen), 64'(n));
        chk("R7", 64'(wr_en), 64'(0));
        chk("R2", 64'(afull_viol), 64'(0));
        chk("R11", 64'(byte_count), 64'(4 * n));
        mon_on = 1'b0;
        afull_on = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1", 64'(wr_en), 64'(0));
        chk("R1", 64'(fail), 64'(0));
        chk("R1", 64'(byte_count), 64'(0));
        chk("R1", 64'(rd_en), 64'(0));
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R8: reads run without any start; garbage data trips the checker
        feed_q.push_back(32'hA5A5_0000);
        feed_q.push_back(32'hA5A5_0001);
        feed_q.push_back(32'hA5A5_0002);
        repeat (8) @(posedge clk);
        #2;
        chk("R8", 64'(byte_count), 64'(12));
        chk("R9", 64'(fail), 64'(1));
        chk("R9", 64'(fail_rd), 64'(32'hA5A5_0000));
        // R10: start clears flag, captures and count
        do_start(3'b000, 27'd0, 27'd0, 30'd1);
        chk("R10", 64'(fail), 64'(0));
        chk("R10", 64'(fail_rd), 64'(0));
        chk("R10", 64'(byte_count), 64'(0));

        // Write runs
        run_write(3'b000, 27'd3, 27'd2, 30'd2, "R4", 1'b1, 1'b1);
        run_write(3'b001, 27'd1, 27'd1, 30'd3, "R4", 1'b0, 1'b0);
        run_write(3'b100, 27'd5, 27'd3, 30'd1, "R6", 1'b1, 1'b0);
        run_write(3'b010, 27'd2, 27'd1, 30'd1, "R5", 1'b0, 1'b0);
        run_write(3'b011, 27'd2, 27'd1, 30'd1, "R5", 1'b1, 1'b0);
        run_write(3'b101, 27'd7, 27'd1, 30'd1, "R5", 1'b0, 1'b0);

        // R7: zero-length run writes nothing
        wr_seen = 0;
        do_start(3'b000, 27'd4, 27'd0, 30'd2);
        repeat (20) @(posedge clk);
        #2 chk("R7", 64'(wr_seen), 64'(0));

        // R3: tag above 32 bits, first three blocks, then abort
        build(64'h1001 * 64'h10_0001, 3, 3'b100);
        exp_q = gm;
        cur_req = "R3";
        mon_on = 1'b1;
        do_start(3'b100, 27'h1001, 27'd1, 30'h10_0001);
        wait (exp_q.size() == 0);
        #1 mon_on = 1'b0;
        do_start(3'b000, 27'd0, 27'd0, 30'd1);
        repeat (4) @(posedge clk);
        #2 chk("R7", 64'(wr_en), 64'(0));

        // R8/R9: clean read run with stalls
        build(64'd6, 4, 3'b001);
        stall_on = 1'b1;
        do_start(3'b001, 27'd3, 27'd0, 30'd2);
        feed_q = gm;
        wait (feed_q.size() == 0);
        repeat (10) @(posedge clk);
        #2;
        chk("R9", 64'(fail), 64'(0));
        chk("R11", 64'(byte_count), 64'(2048));

        // R9: two corruptions, only the first is captured
        build(64'd6, 4, 3'b100);
        do_start(3'b100, 27'd3, 27'd0, 30'd2);
        feed_q = gm;
        feed_q[300] = gm[300] ^ 32'h1;
        feed_q[400] = gm[400] ^ 32'hFF;
        wait (feed_q.size() == 0);
        repeat (10) @(posedge clk);
        #2;
        chk("R9", 64'(fail), 64'(1));
        chk("R9", 64'(fail_exp), 64'(gm[300]));
        chk("R9", 64'(fail_rd), 64'(gm[300] ^ 32'h1));
        chk("R9", 64'(fail_byte), 64'(176));
        chk("R9", 64'(fail_file), 64'(4));
        chk("R11", 64'(byte_count), 64'(2048));
        stall_on = 1'b0;

        // R10: a new start wipes the capture
        do_start(3'b000, 27'd9, 27'd0, 30'd2);
        chk("R10", 64'(fail), 64'(0));
        chk("R10", 64'(fail_file), 64'(0));
        chk("R10", 64'(fail_byte), 64'(0));

        repeat (5) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog act=expired exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule